// File: doc/BRIEF.md
# Two-Slot Fetch and Issue Checker

This block is the front end of a two-wide, in-order machine whose instruction pairs are arranged by the compiler. On every cycle it presents an 8-byte-aligned fetch address and receives a 64-bit word pair. The low word (byte offset 0) belongs to the arithmetic/branch slot. The high word (byte offset 4) belongs to the memory slot. The hardware does no pairing of its own. It only confirms that the compiler's pair obeys the slot rules and holds no dependence inside itself. It then issues both words together on the next clock edge.

When the pair is legal, the fetch address moves on by 8. If the arithmetic slot holds a jump, or a conditional branch whose condition input is high, the fetch address moves to the branch target with its low three bits cleared. A rejected pair, or a misaligned fetch address, issues nothing and freezes the fetch address. A redirect input, driven by trap or recovery logic, is the only way out of that state.

Top module: `di_pair_issue`

## Requirements
- R1: While reset is low, `fetch_pc` equals the reset address (default 0), and `issue_valid`, `issue_taken`, `err_align`, `err_class` and `err_dep` are all 0.
- R2: The opcode sits in bits [31:28] of each word: 0 no-op, 1 arithmetic, 2 jump, 3 conditional branch, 4 load, 5 store, 6 to 15 undefined. The low word of `fetch_pair` may hold only codes 0 to 3, and the high word only 0, 4 or 5. Any other combination sets `err_class` one cycle later and nothing issues. A no-op is legal in either slot.
- R3: Register fields are destination [27:23], first source [22:18] and second source [17:13]. An arithmetic instruction in the low slot writes its destination. A load reads its first source, and a store reads both sources. If the memory word reads the register the arithmetic word writes, `err_dep` is set one cycle later and nothing issues. Jumps and branches write no register.
- R4: An arithmetic word and a load that name the same destination set `err_dep`.
- R5: A legal pair gives, one cycle later, `issue_valid`=1 with `issue_alu` equal to the low word, `issue_mem` equal to the high word, and `issue_pc` equal to the fetch address of the pair.
- R6: After a legal pair with no taken branch, `fetch_pc` advances by 8.
- R7: A jump is always taken, and a conditional branch is taken when `branch_cond` is 1. The immediate is bits [12:0], a signed word offset. The target is the pair address plus four times the immediate, with bits [2:0] cleared. `issue_taken` is set together with `issue_valid`.
- R8: A fetch address whose bits [2:0] are not zero sets `err_align` only, whatever the words hold, and nothing issues.
- R9: Whenever an error flag is set, `fetch_pc` has kept its previous value.
- R10: `redir_valid` takes priority over everything else. The fetched pair is dropped without any error, and `fetch_pc` becomes `redir_pc` on the next cycle.
- R11: Register 0 is never written, so a destination of 0 never forms a dependence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| redir_valid | input | 1 | Force the fetch address to `redir_pc` |
| redir_pc | input | 32 | Redirect address |
| branch_cond | input | 1 | Outcome of the condition for a conditional branch in the low slot |
| fetch_pair | input | 64 | Word pair read at `fetch_pc`; low word is offset 0 |
| fetch_pc | output | 32 | Current fetch address |
| issue_valid | output | 1 | A pair was issued |
| issue_taken | output | 1 | The issued pair redirected fetch to its branch target |
| issue_pc | output | 32 | Address of the issued pair |
| issue_alu | output | 32 | Issued arithmetic/branch-slot word |
| issue_mem | output | 32 | Issued memory-slot word |
| err_align | output | 1 | Misaligned fetch address |
| err_class | output | 1 | Word of the wrong class in a slot |
| err_dep | output | 1 | Dependence inside the pair |

## Verification
A taken branch and a pairing error can fall on the same cycle. A conditional branch may sit next to a store whose source matches nothing, next to an undefined memory-slot code, or next to a load that collides with its register fields. The bench sweeps every pair of opcode values under both condition values, with and without colliding register fields. It judges each cycle by whether the fetch address jumped to the target, advanced by 8 or held, and by which single flag rose. A second overlap, a redirect arriving while the address is misaligned or frozen by an error, is provoked directly. It is judged by the absence of any error flag and by the new fetch address.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_NOP = 4'd0,
      OPC_ALU = 4'd1,
      OPC_JMP = 4'd2,
      OPC_BRC = 4'd3,
      OPC_LD  = 4'd4,
      OPC_ST  = 4'd5
   } opc_e;

   typedef struct packed {
      logic wr_dst;
      logic rd_src1;
      logic rd_src2;
      logic jmp;
      logic brc;
   } slot_info_t;

endpackage

// File: rtl/di_slot_decode.sv
module di_slot_decode
   import dual_issue_pkg::*;
#(
   parameter int INSN_W   = 32,
   parameter bit MEM_SLOT = 1'b0
) (
   input  logic [INSN_W-1:0] insn,
   output slot_info_t        info,
   output logic              legal
);

   logic [OPC_W-1:0] opc;
   assign opc = insn[INSN_W-1 -: OPC_W];

   always_comb begin
      info = '0;
      case (opc)
         OPC_ALU: begin
            info.wr_dst  = 1'b1;
            info.rd_src1 = 1'b1;
            info.rd_src2 = 1'b1;
         end
         OPC_JMP: info.jmp = 1'b1;
         OPC_BRC: begin
            info.brc     = 1'b1;
            info.rd_src1 = 1'b1;
            info.rd_src2 = 1'b1;
         end
         OPC_LD: begin
            info.wr_dst  = 1'b1;
            info.rd_src1 = 1'b1;
         end
         OPC_ST: begin
            info.rd_src1 = 1'b1;
            info.rd_src2 = 1'b1;
         end
         default: info = '0;
      endcase
   end

   // slot class rule: the variant is picked by which slot this decoder serves
   generate
      if (MEM_SLOT) begin : g_mem_slot
         assign legal = (opc == OPC_NOP) || (opc == OPC_LD) || (opc == OPC_ST);
      end else begin : g_alu_slot
         assign legal = (opc == OPC_NOP) || (opc == OPC_ALU) ||
                        (opc == OPC_JMP) || (opc == OPC_BRC);
      end
   endgenerate

endmodule

// File: rtl/di_pair_hazard.sv
module di_pair_hazard
   import dual_issue_pkg::*;
#(
   parameter int REG_BITS  = 5,
   parameter bit ZERO_REG  = 1'b1,
   parameter bit CHECK_WAW = 1'b1
) (
   input  slot_info_t          a_info,
   input  logic [REG_BITS-1:0] a_dst,
   input  slot_info_t          m_info,
   input  logic [REG_BITS-1:0] m_dst,
   input  logic [REG_BITS-1:0] m_src1,
   input  logic [REG_BITS-1:0] m_src2,
   output logic                hazard
);

   logic a_writes;
   logic raw_hit;
   logic waw_hit;

   generate
      if (ZERO_REG) begin : g_zero_reg
         assign a_writes = a_info.wr_dst && (a_dst != '0);
      end else begin : g_no_zero_reg
         assign a_writes = a_info.wr_dst;
      end
   endgenerate

   assign raw_hit = a_writes &&
                    ((m_info.rd_src1 && (m_src1 == a_dst)) ||
                     (m_info.rd_src2 && (m_src2 == a_dst)));

   generate
      if (CHECK_WAW) begin : g_waw
         assign waw_hit = a_writes && m_info.wr_dst && (m_dst == a_dst);
      end else begin : g_no_waw
         assign waw_hit = 1'b0;
      end
   endgenerate

   assign hazard = raw_hit || waw_hit;

endmodule

// File: rtl/di_next_pc.sv
module di_next_pc #(
   parameter int PC_W  = 32,
   parameter int IMM_W = 13
) (
   input  logic [PC_W-1:0]  pc,
   input  logic             redir_valid,
   input  logic [PC_W-1:0]  redir_pc,
   input  logic             advance,
   input  logic             take,
   input  logic [IMM_W-1:0] imm,
   output logic [PC_W-1:0]  pc_next
);

   localparam int EXT_W = PC_W - IMM_W - 2;

   logic [PC_W-1:0] offset;
   logic [PC_W-1:0] sum;
   logic [PC_W-1:0] target;

   assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
   assign sum    = pc + offset;
   assign target = {sum[PC_W-1:3], 3'b000};

   always_comb begin
      if (redir_valid)   pc_next = redir_pc;
      else if (!advance) pc_next = pc;
      else if (take)     pc_next = target;
      else               pc_next = pc + PC_W'(8);
   end

endmodule

// File: rtl/di_pair_issue.sv
module di_pair_issue
   import dual_issue_pkg::*;
#(
   parameter int              PC_W      = 32,
   parameter int              INSN_W    = 32,
   parameter int              REG_BITS  = 5,
   parameter logic [PC_W-1:0] RESET_PC  = '0,
   parameter bit              ZERO_REG  = 1'b1,
   parameter bit              CHECK_WAW = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                redir_valid,
   input  logic [PC_W-1:0]     redir_pc,
   input  logic                branch_cond,
   input  logic [2*INSN_W-1:0] fetch_pair,
   output logic [PC_W-1:0]     fetch_pc,
   output logic                issue_valid,
   output logic                issue_taken,
   output logic [PC_W-1:0]     issue_pc,
   output logic [INSN_W-1:0]   issue_alu,
   output logic [INSN_W-1:0]   issue_mem,
   output logic                err_align,
   output logic                err_class,
   output logic                err_dep
);

   localparam int IMM_W    = INSN_W - OPC_W - 3*REG_BITS;
   localparam int DST_LSB  = INSN_W - OPC_W - REG_BITS;
   localparam int SRC1_LSB = DST_LSB - REG_BITS;
   localparam int SRC2_LSB = SRC1_LSB - REG_BITS;
   localparam int NSLOT    = 2;

   // elaboration-time parameter checks
   if (IMM_W < 1) begin : g_bad_imm
      $error("di_pair_issue: INSN_W leaves no room for an immediate");
   end
   if (PC_W < IMM_W + 3) begin : g_bad_pc
      $error("di_pair_issue: PC_W too narrow for the branch offset");
   end
   if (RESET_PC[2:0] != 3'b000) begin : g_bad_reset
      $error("di_pair_issue: RESET_PC must be 8-byte aligned");
   end

   logic [PC_W-1:0]   pc_q;
   logic [PC_W-1:0]   pc_nxt;
   logic [INSN_W-1:0] word [NSLOT];
   slot_info_t        info [NSLOT];
   logic              legal [NSLOT];
   logic              misaligned;
   logic              class_bad;
   logic              hazard;
   logic              take;
   logic              pair_ok;

   genvar s;
   generate
      for (s = 0; s < NSLOT; s++) begin : g_slot
         assign word[s] = fetch_pair[s*INSN_W +: INSN_W];
         di_slot_decode #(
            .INSN_W  (INSN_W),
            .MEM_SLOT(s == 1)
         ) i_dec (
            .insn (word[s]),
            .info (info[s]),
            .legal(legal[s])
         );
      end
   endgenerate

   di_pair_hazard #(
      .REG_BITS (REG_BITS),
      .ZERO_REG (ZERO_REG),
      .CHECK_WAW(CHECK_WAW)
   ) i_hazard (
      .a_info(info[0]),
      .a_dst (word[0][DST_LSB +: REG_BITS]),
      .m_info(info[1]),
      .m_dst (word[1][DST_LSB +: REG_BITS]),
      .m_src1(word[1][SRC1_LSB +: REG_BITS]),
      .m_src2(word[1][SRC2_LSB +: REG_BITS]),
      .hazard(hazard)
   );

   assign misaligned = (pc_q[2:0] != 3'b000);
   assign class_bad  = !legal[0] || !legal[1];
   assign take       = info[0].jmp || (info[0].brc && branch_cond);
   assign pair_ok    = !redir_valid && !misaligned && !class_bad && !hazard;

   di_next_pc #(
      .PC_W (PC_W),
      .IMM_W(IMM_W)
   ) i_npc (
      .pc         (pc_q),
      .redir_valid(redir_valid),
      .redir_pc   (redir_pc),
      .advance    (pair_ok),
      .take       (take),
      .imm        (word[0][IMM_W-1:0]),
      .pc_next    (pc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q        <= RESET_PC;
         issue_valid <= 1'b0;
         issue_taken <= 1'b0;
         issue_pc    <= '0;
         issue_alu   <= '0;
         issue_mem   <= '0;
         err_align   <= 1'b0;
         err_class   <= 1'b0;
         err_dep     <= 1'b0;
      end else begin
         pc_q        <= pc_nxt;
         issue_valid <= pair_ok;
         issue_taken <= pair_ok && take;
         err_align   <= !redir_valid && misaligned;
         err_class   <= !redir_valid && !misaligned && class_bad;
         err_dep     <= !redir_valid && !misaligned && !class_bad && hazard;
         if (pair_ok) begin
            issue_pc  <= pc_q;
            issue_alu <= word[0];
            issue_mem <= word[1];
         end
      end
   end

   assign fetch_pc = pc_q;

endmodule

// File: rtl/di_pair_issue_chk.sv
module di_pair_issue_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            redir_valid,
   input logic [PC_W-1:0] redir_pc,
   input logic [PC_W-1:0] fetch_pc,
   input logic            issue_valid,
   input logic            issue_taken,
   input logic [PC_W-1:0] issue_pc,
   input logic            err_align,
   input logic            err_class,
   input logic            err_dep
);

   // R8: at most one outcome per cycle
   a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({issue_valid, err_align, err_class, err_dep}));

   // R5: only aligned pairs are issued
   a_r5_issue_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_pc[2:0] == 3'b000));

   // R6: sequential step of 8
   a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_taken) |-> (fetch_pc == issue_pc + PC_W'(8)));

   // R7: a taken branch comes with an issue and lands aligned
   a_r7_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      issue_taken |-> (issue_valid && (fetch_pc[2:0] == 3'b000)));

   // R9: errors freeze the fetch address
   a_r9_hold_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (err_align || err_class || err_dep)) |-> (fetch_pc == $past(fetch_pc)));

   // R10: redirect squashes and loads the address
   a_r10_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(redir_valid)) |->
         (!issue_valid && !err_align && !err_class && !err_dep &&
          (fetch_pc == $past(redir_pc))));

endmodule

bind di_pair_issue di_pair_issue_chk #(.PC_W(PC_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .redir_valid(redir_valid),
   .redir_pc   (redir_pc),
   .fetch_pc   (fetch_pc),
   .issue_valid(issue_valid),
   .issue_taken(issue_taken),
   .issue_pc   (issue_pc),
   .err_align  (err_align),
   .err_class  (err_class),
   .err_dep    (err_dep)
);

// File: tb/test_di_pair_issue.sv
module test_di_pair_issue;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        redir_valid = 1'b0;
   logic [31:0] redir_pc = '0;
   logic        branch_cond = 1'b0;
   logic [63:0] fetch_pair = '0;
   logic [31:0] fetch_pc;
   logic        issue_valid;
   logic        issue_taken;
   logic [31:0] issue_pc;
   logic [31:0] issue_alu;
   logic [31:0] issue_mem;
   logic        err_align;
   logic        err_class;
   logic        err_dep;

   int          n_chk = 0;
   int          n_err = 0;
   logic [31:0] model_pc = '0;

   always #10 clk = ~clk;

   di_pair_issue i_di_pair_issue (
      .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
      .branch_cond(branch_cond), .fetch_pair(fetch_pair), .fetch_pc(fetch_pc),
      .issue_valid(issue_valid), .issue_taken(issue_taken), .issue_pc(issue_pc),
      .issue_alu(issue_alu), .issue_mem(issue_mem), .err_align(err_align),
      .err_class(err_class), .err_dep(err_dep)
   );

   function automatic logic [31:0] mk(input logic [3:0] op, input logic [4:0] rd,
                                      input logic [4:0] ra, input logic [4:0] rb,
                                      input logic [12:0] imm);
      return {op, rd, ra, rb, imm};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic run_redirect(input string req, input logic [31:0] p);
      redir_valid = 1'b1;
      redir_pc    = p;
      fetch_pair  = {mk(4'd4, 5'd1, 5'd2, 5'd0, 13'd0), mk(4'd2, 5'd0, 5'd0, 5'd0, 13'd5)};
      branch_cond = 1'b1;
      @(negedge clk);
      chk(req, "redirect fetch_pc", fetch_pc, p);
      chk(req, "redirect squash", {issue_valid, err_align, err_class, err_dep}, 0);
      model_pc    = p;
      redir_valid = 1'b0;
   endtask

   task automatic run_pair(input string req, input logic [31:0] w0,
                           input logic [31:0] w1, input logic cond);
      logic [3:0]  o0, o1;
      logic        ok, wr, dep, mis, valid, taken;
      logic [31:0] tgt, npc;
      o0    = w0[31:28];
      o1    = w1[31:28];
      ok    = (o0 <= 4'd3) && (o1 == 4'd0 || o1 == 4'd4 || o1 == 4'd5);
      wr    = (o0 == 4'd1) && (w0[27:23] != 5'd0);
      dep   = wr && ((((o1 == 4'd4) || (o1 == 4'd5)) && (w1[22:18] == w0[27:23])) ||
                     ((o1 == 4'd5) && (w1[17:13] == w0[27:23])) ||
                     ((o1 == 4'd4) && (w1[27:23] == w0[27:23])));
      mis   = (model_pc[2:0] != 3'b000);
      valid = !mis && ok && !dep;
      taken = valid && ((o0 == 4'd2) || ((o0 == 4'd3) && cond));
      tgt   = model_pc + {{17{w0[12]}}, w0[12:0], 2'b00};
      tgt[2:0] = 3'b000;
      npc   = !valid ? model_pc : (taken ? tgt : model_pc + 32'd8);
      redir_valid = 1'b0;
      fetch_pair  = {w1, w0};
      branch_cond = cond;
      @(negedge clk);
      chk(req, "issue_valid", issue_valid, valid);
      chk(req, "issue_taken", issue_taken, taken);
      chk(req, "err_align", err_align, mis);
      chk(req, "err_class", err_class, !mis && !ok);
      chk(req, "err_dep", err_dep, !mis && ok && dep);
      chk(req, "fetch_pc", fetch_pc, npc);
      if (valid) begin
         chk(req, "issue_alu", issue_alu, w0);
         chk(req, "issue_mem", issue_mem, w1);
         chk(req, "issue_pc", issue_pc, model_pc);
      end
      model_pc = npc;
   endtask

   initial begin
      #(20 * 150000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // R1: reset state
      chk("R1", "fetch_pc", fetch_pc, 32'h0);
      chk("R1", "flags", {issue_valid, issue_taken, err_align, err_class, err_dep}, 0);
      rst_n = 1'b1;

      run_redirect("R10", 32'h40);
      // R6: sequential stream
      run_pair("R6", mk(4'd1, 5'd3, 5'd1, 5'd2, 13'd0), mk(4'd4, 5'd4, 5'd5, 5'd0, 13'd8), 1'b0);
      run_pair("R6", mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), mk(4'd5, 5'd0, 5'd6, 5'd7, 13'd4), 1'b0);
      run_pair("R6", mk(4'd1, 5'd9, 5'd9, 5'd9, 13'd0), mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), 1'b0);
      // R11: destination 0 never collides
      run_pair("R11", mk(4'd1, 5'd0, 5'd1, 5'd2, 13'd0), mk(4'd5, 5'd0, 5'd0, 5'd0, 13'd0), 1'b0);
      run_pair("R11", mk(4'd1, 5'd0, 5'd1, 5'd2, 13'd0), mk(4'd4, 5'd0, 5'd0, 5'd0, 13'd0), 1'b0);
      // R4 then R9: write-write collision freezes the address
      run_pair("R4", mk(4'd1, 5'd6, 5'd1, 5'd2, 13'd0), mk(4'd4, 5'd6, 5'd2, 5'd0, 13'd0), 1'b0);
      run_pair("R9", mk(4'd1, 5'd6, 5'd1, 5'd2, 13'd0), mk(4'd4, 5'd6, 5'd2, 5'd0, 13'd0), 1'b1);
      run_pair("R9", mk(4'd9, 5'd0, 5'd0, 5'd0, 13'd0), mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), 1'b0);
      run_pair("R2", mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), 1'b0);
      // R8: misaligned address, even with a bad class
      run_redirect("R10", 32'h204);
      run_pair("R8", mk(4'd1, 5'd3, 5'd1, 5'd2, 13'd0), mk(4'd4, 5'd4, 5'd5, 5'd0, 13'd0), 1'b0);
      run_pair("R8", mk(4'd4, 5'd3, 5'd1, 5'd2, 13'd0), mk(4'd1, 5'd4, 5'd5, 5'd0, 13'd0), 1'b1);
      run_redirect("R10", 32'h300);
      // R7: branch not taken, then taken backwards, then jump forward
      run_pair("R7", mk(4'd3, 5'd0, 5'd1, 5'd2, 13'h1FF0), mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), 1'b0);
      run_pair("R7", mk(4'd3, 5'd0, 5'd1, 5'd2, 13'h1FF0), mk(4'd0, 5'd0, 5'd0, 5'd0, 13'd0), 1'b1);
      run_pair("R7", mk(4'd2, 5'd0, 5'd0, 5'd0, 13'd7), mk(4'd5, 5'd0, 5'd3, 5'd4, 13'd0), 1'b0);

      // sweep over every opcode pair, both conditions, with and without collisions
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            for (int c = 0; c < 4; c++) begin
               logic [4:0]  ra, rb, rd1;
               logic [12:0] imm;
               logic [31:0] w0, w1;
               string       tag;
               int          sel;
               sel = (a + b) % 3;
               ra  = 5'd9;
               rb  = 5'd10;
               rd1 = 5'd11;
               if (c >= 2) begin
                  if (sel == 0) ra = 5'd7;
                  else if (sel == 1) rb = 5'd7;
                  else rd1 = 5'd7;
               end
               imm = 13'((a * 97 + b * 31 + c * 7) - 600);
               w0  = mk(4'(a), 5'd7, 5'd1, 5'd2, imm);
               w1  = mk(4'(b), rd1, ra, rb, 13'd16);
               if (a > 3 || !(b == 0 || b == 4 || b == 5)) tag = "R2";
               else if (c >= 2 && a == 1) tag = (sel == 2) ? "R4" : "R3";
               else if (a == 2 || a == 3) tag = "R7";
               else tag = "R5";
               run_redirect("R10", 32'h1000 + 32'(a * 16 + b) * 32'h40);
               run_pair(tag, w0, w1, c[0]);
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule